// File: doc/BRIEF.md
# Supply Supervisor with Access Gating and Battery Health Tracking

This block watches digital comparator flags that describe the main supply and the backup battery. It produces three signals from them. An access enable blocks every memory and clock access while the supply is too low, and also during a hold-off period after the supply returns. A supply-select output moves the load onto the battery when the supply drops below the lower switchover level. A battery-low flag, active low in open-drain style, reports a weak battery.

Timing comes from a slow tick enable that lasts one clock cycle. The recovery hold-off and the periodic battery-test interval are counted in ticks and set by parameters. A tick of 1 ms with the default values gives an 80 ms hold-off and a 24 hour test interval. Simulation can use much smaller values.

The sequencing logic restarts each time the supply falls below the power-fail level. The battery flags model battery-backed state: they keep their values through a supply loss, and only the system reset clears them. The result of the power-up test also feeds a separate data-suspect bit. A periodic test never changes that bit.

Top module: `pwr_supervisor`

## Requirements
- R1: While `vcc_above_pfd` is 0, `access_en` is 0. It drops to 0 after the first rising clock edge that samples `vcc_above_pfd` = 0.
- R2: `use_battery` equals the inverse of `vcc_above_so` as sampled at the previous rising edge: 1 means the battery supplies the load.
- R3: Sequencing is active when `rst_n` = 1 and `vcc_above_pfd` = 1. `access_en` rises at the edge that samples the REC_TICKS-th tick counted since sequencing became active. It stays 0 before that edge.
- R4: At the first edge with sequencing active, a power-up test runs. It sets `batt_low_n` = `batt_ok` and `data_suspect` = NOT `batt_ok`.
- R5: A periodic test runs at every INT_TICKS-th tick counted since sequencing became active. It sets `batt_low_n` = `batt_ok` and leaves `data_suspect` unchanged.
- R6: The battery-low flag is sticky. Changes on `batt_ok` between tests do not affect `batt_low_n`.
- R7: While `vcc_above_pfd` is 0, no test runs. `batt_low_n` and `data_suspect` keep their values until a test or `rst_n` changes them.
- R8: A supply drop restarts the sequencing when the supply returns. The recovery count begins again, the tick count for the interval begins again from zero, and a new power-up test runs.
- R9: A synchronous active-low `rst_n` sets `access_en` = 0, `use_battery` = 0, `batt_low_n` = 1 and `data_suspect` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle slow timebase enable |
| vcc_above_pfd | input | 1 | Supply above the power-fail level |
| vcc_above_so | input | 1 | Supply above the battery switchover level |
| batt_ok | input | 1 | Battery comparator reports a healthy voltage |
| access_en | output | 1 | 1 when memory and clock accesses are allowed |
| use_battery | output | 1 | 1 selects the battery as supply source |
| batt_low_n | output | 1 | 0 signals a low battery (open-drain style) |
| data_suspect | output | 1 | 1 when the latest power-up test failed |

## Verification
The assertions check four properties on every cycle. Access is withdrawn one edge after the supply falls. The supply select follows the switchover flag. The battery flags stay frozen while the supply is low. When `access_en` rises, exactly the recovery number of ticks has passed, which a checker-side counter confirms.

Other behaviour needs whole scenarios from the bench. These include the stickiness of the flag against `batt_ok` changes between tests, the split between power-up and periodic results in `data_suspect`, and the restart of the interval count after a mid-interval supply drop. The bench sweeps each tick position of the recovery and interval windows for both battery outcomes at power-up.

// File: rtl/pwrsup_pkg.sv
// Package: shared helpers and types for the supply supervisor.
// Assumes: counter limits are at least 1.
package pwrsup_pkg;

    // Width needed to count 0..n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Kind of battery test that fires in a given cycle.
    typedef enum logic [1:0] {
        TEST_NONE     = 2'd0,
        TEST_POWERUP  = 2'd1,
        TEST_PERIODIC = 2'd2
    } test_kind_e;

endpackage

// File: rtl/pwrsup_tick_counter.sv
// Module: modulo-LIMIT counter of enable pulses.
// done is high in the cycle whose enable completes a full count.
// Assumes: rst_n is synchronous and active low.
module pwrsup_tick_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    import pwrsup_pkg::*;

    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Terminal detect on the enabled cycle.
    assign done = en && (cnt == LAST);

    // Count enables, wrapping to zero after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrsup_recovery.sv
// Module: power-up hold-off. Access is granted after REC_TICKS ticks
// counted from the release of the domain reset.
// Assumes: dom_rst_n drops whenever the supply is below the power-fail level.
module pwrsup_recovery #(
    parameter int REC_TICKS = 80
) (
    input  logic clk,
    input  logic dom_rst_n,
    input  logic tick,
    output logic access_en
);
    logic cnt_en;
    logic cnt_done;

    // Count only while still holding off.
    assign cnt_en = tick && !access_en;

    pwrsup_tick_counter #(.LIMIT(REC_TICKS)) u_cnt (
        .clk   (clk),
        .rst_n (dom_rst_n),
        .en    (cnt_en),
        .done  (cnt_done)
    );

    // Grant access once the hold-off count completes; keep it until reset.
    always_ff @(posedge clk) begin
        if (!dom_rst_n) begin
            access_en <= 1'b0;
        end else if (cnt_done) begin
            access_en <= 1'b1;
        end
    end
endmodule

// File: rtl/pwrsup_batt_monitor.sv
// Module: battery test scheduler and sticky result flags.
// A power-up test runs on the first active cycle and a periodic test
// every INT_TICKS ticks after that. Flags reset only on rst_n, so they
// hold through a supply loss.
// Assumes: dom_rst_n is low whenever the supply is not nominal.
module pwrsup_batt_monitor #(
    parameter int INT_TICKS = 86_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dom_rst_n,
    input  logic tick,
    input  logic batt_ok,
    output logic batt_low_n,
    output logic data_suspect
);
    import pwrsup_pkg::*;

    logic       armed;
    logic       period_done;
    test_kind_e test_kind;

    pwrsup_tick_counter #(.LIMIT(INT_TICKS)) u_interval (
        .clk   (clk),
        .rst_n (dom_rst_n),
        .en    (tick),
        .done  (period_done)
    );

    // Pick which test (if any) fires in this cycle.
    always_comb begin
        if (!dom_rst_n) begin
            test_kind = TEST_NONE;
        end else if (!armed) begin
            test_kind = TEST_POWERUP;
        end else if (period_done) begin
            test_kind = TEST_PERIODIC;
        end else begin
            test_kind = TEST_NONE;
        end
    end

    // Mark that the power-up test of this supply session has run.
    always_ff @(posedge clk) begin
        if (!dom_rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // Latch test results; power-up results also drive the suspect bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batt_low_n   <= 1'b1;
            data_suspect <= 1'b0;
        end else begin
            case (test_kind)
                TEST_POWERUP: begin
                    batt_low_n   <= batt_ok;
                    data_suspect <= !batt_ok;
                end
                TEST_PERIODIC: begin
                    batt_low_n   <= batt_ok;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/pwr_supervisor.sv
// Module: top of the supply supervisor. It gates accesses, selects the
// battery below switchover, and schedules battery tests.
// Assumes: comparator flags are already synchronous to clk; tick is a
// one-cycle enable.
module pwr_supervisor #(
    parameter int REC_TICKS = 80,
    parameter int INT_TICKS = 86_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vcc_above_pfd,
    input  logic vcc_above_so,
    input  logic batt_ok,
    output logic access_en,
    output logic use_battery,
    output logic batt_low_n,
    output logic data_suspect
);
    logic dom_rst_n;

    // Sequencing domain runs only with nominal supply and no reset.
    assign dom_rst_n = rst_n && vcc_above_pfd;

    pwrsup_recovery #(.REC_TICKS(REC_TICKS)) u_recovery (
        .clk       (clk),
        .dom_rst_n (dom_rst_n),
        .tick      (tick),
        .access_en (access_en)
    );

    pwrsup_batt_monitor #(.INT_TICKS(INT_TICKS)) u_batt (
        .clk          (clk),
        .rst_n        (rst_n),
        .dom_rst_n    (dom_rst_n),
        .tick         (tick),
        .batt_ok      (batt_ok),
        .batt_low_n   (batt_low_n),
        .data_suspect (data_suspect)
    );

    // Register the supply-source select from the switchover comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_battery <= 1'b0;
        end else begin
            use_battery <= !vcc_above_so;
        end
    end
endmodule

// File: rtl/pwrsup_checker.sv
// Module: property checker for pwr_supervisor, attached by bind.
// Keeps its own tick count to check the recovery window.
module pwrsup_checker #(
    parameter int REC_TICKS = 80
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic vcc_above_pfd,
    input logic vcc_above_so,
    input logic batt_ok,
    input logic access_en,
    input logic use_battery,
    input logic batt_low_n,
    input logic data_suspect
);
    import pwrsup_pkg::*;

    localparam int CW = cnt_width(REC_TICKS + 1);

    logic [CW-1:0] ticks_seen;

    // Count ticks since the supply became nominal, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !vcc_above_pfd) begin
            ticks_seen <= '0;
        end else if (tick && ticks_seen != CW'(REC_TICKS)) begin
            ticks_seen <= ticks_seen + 1'b1;
        end
    end

    p_block_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_above_pfd |=> !access_en);

    p_batt_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_above_so |=> use_battery);

    p_vcc_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_above_so |=> !use_battery);

    p_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_en) |-> ($past(tick) && $past(ticks_seen) == CW'(REC_TICKS - 1)));

    p_low_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batt_low_n) |-> !$past(batt_ok));

    p_ok_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_low_n) |-> $past(batt_ok));

    p_frozen_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_above_pfd |=> ($stable(batt_low_n) && $stable(data_suspect)));

    p_suspect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_suspect) |-> (!$past(batt_ok) && $past(vcc_above_pfd)));
endmodule

bind pwr_supervisor pwrsup_checker #(.REC_TICKS(REC_TICKS)) u_pwrsup_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .vcc_above_pfd (vcc_above_pfd),
    .vcc_above_so  (vcc_above_so),
    .batt_ok       (batt_ok),
    .access_en     (access_en),
    .use_battery   (use_battery),
    .batt_low_n    (batt_low_n),
    .data_suspect  (data_suspect)
);

// File: tb/pwr_supervisor_test.sv
`timescale 1ns/1ps
module pwr_supervisor_test;
    localparam int REC = 5;
    localparam int INTV = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pfd = 1'b1;
    logic so = 1'b1;
    logic ok = 1'b1;
    logic access_en, use_battery, batt_low_n, data_suspect;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_supervisor #(.REC_TICKS(REC), .INT_TICKS(INTV)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .vcc_above_pfd (pfd),
        .vcc_above_so  (so),
        .batt_ok       (ok),
        .access_en     (access_en),
        .use_battery   (use_battery),
        .batt_low_n    (batt_low_n),
        .data_suspect  (data_suspect)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock with the given tick level; returns at the following negedge.
    task automatic cyc(input logic t);
        tick = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // One tick followed by an idle cycle.
    task automatic tk();
        cyc(1'b1);
        cyc(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(1'b1);
        // R9 reset state
        chk("R9 access_en", access_en, 1'b0);
        chk("R9 use_battery", use_battery, 1'b0);
        chk("R9 batt_low_n", batt_low_n, 1'b1);
        chk("R9 data_suspect", data_suspect, 1'b0);

        for (int trial = 0; trial < 2; trial++) begin
            if (trial > 0) begin
                // R1: one edge with supply low removes access
                chk("R1 pre access_en", access_en, 1'b1);
                pfd = 1'b0;
                cyc(1'b0);
                chk("R1 access_en", access_en, 1'b0);
                // R7: battery changes and ticks while low have no effect
                ok = 1'b1;
                for (int j = 0; j < 3; j++) begin
                    tk();
                    chk("R7 batt_low_n held", batt_low_n, 1'b0);
                    chk("R7 data_suspect held", data_suspect, 1'b1);
                    chk("R1 access_en low", access_en, 1'b0);
                end
            end
            rst_n = 1'b1;
            pfd = 1'b0;
            so = 1'b0;
            cyc(1'b0);
            cyc(1'b0);
            chk("R2 battery selected", use_battery, 1'b1);
            so = 1'b1;
            cyc(1'b0);
            chk("R2 vcc selected", use_battery, 1'b0);
            // Supply returns; power-up test result
            ok = logic'(trial);
            pfd = 1'b1;
            cyc(1'b0);
            chk("R4 batt_low_n", batt_low_n, logic'(trial));
            chk("R4 data_suspect", data_suspect, !logic'(trial));
            chk("R3 held at start", access_en, 1'b0);
            ok = 1'b1;
            // Sweep every tick through two intervals
            for (int n = 1; n <= 2 * INTV; n++) begin
                logic exp_bl;
                tk();
                chk("R3 access_en", access_en, (n >= REC) ? 1'b1 : 1'b0);
                if (n < INTV) exp_bl = logic'(trial);
                else if (n < 2 * INTV) exp_bl = 1'b1;
                else exp_bl = 1'b0;
                if (n == INTV) chk("R5 periodic pass", batt_low_n, exp_bl);
                else if (n == 2 * INTV) chk("R5 periodic fail", batt_low_n, exp_bl);
                else chk("R6 sticky", batt_low_n, exp_bl);
                chk("R5 suspect unchanged", data_suspect, !logic'(trial));
                if (n == INTV) ok = 1'b0;
            end
        end

        // R8: drop mid-interval and check restart of all counting
        pfd = 1'b0;
        cyc(1'b0);
        ok = 1'b1;
        pfd = 1'b1;
        cyc(1'b0);
        chk("R8 power-up retest", batt_low_n, 1'b1);
        chk("R8 suspect cleared", data_suspect, 1'b0);
        for (int n = 1; n <= 4; n++) tk();
        pfd = 1'b0;
        cyc(1'b0);
        chk("R1 access_en after drop", access_en, 1'b0);
        pfd = 1'b1;
        cyc(1'b0);
        ok = 1'b0;
        for (int n = 1; n <= INTV; n++) begin
            tk();
            chk("R8 recovery restarted", access_en, (n >= REC) ? 1'b1 : 1'b0);
            chk("R8 interval restarted", batt_low_n, (n < INTV) ? 1'b1 : 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule